// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a single asynchronous serial line into received characters. A sample-enable pulse, generated elsewhere at either 8 or 16 times the bit rate, paces all decisions while the logic itself runs on one system clock. The line first passes through a two-flop synchronizer. The receiver then waits for a start bit that stays low for half a bit time. It samples the data bits, an optional parity bit and one stop bit near the centre of each bit cell. It delivers the character with a one-cycle valid strobe and with parity-error and framing-error flags.

Run-time inputs choose the character length (5 to 8 bits, or 9 bits through a separate ninth-bit control), the bit order, the parity mode and the oversampling factor. The receiver captures these settings at the moment it confirms a start bit, so they may be changed freely while a character is in flight. The receiver always checks exactly one stop bit and resumes the start search on the very next sample. This keeps it aligned with a sender that uses one or two stop bits.

Top module: `serial_rx`

## Requirements
- R1: A start bit is confirmed only when `rxd` is sampled low on consecutive sample pulses for half a bit: 8 samples at 16x, 4 samples at 8x. A low run that is one sample shorter is discarded, and the receiver returns to searching.
- R2: `cfg_over8` selects the oversampling at run time (0 = 16x, 1 = 8x). After start confirmation, every later bit is sampled once per 16 (or 8) sample pulses.
- R3: `cfg_len` values 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. `cfg_nine`=1 overrides this to 9 data bits. Bits of `rx_data` above the character length read 0.
- R4: With `cfg_msb_first`=0, the first data bit on the line lands in `rx_data[0]`. With 1, it lands in the most significant bit of the character, `rx_data[n-1]`.
- R5: `cfg_parity` selects the parity mode: 0 even, 1 odd, 2 parity bit forced to 0, 3 parity bit forced to 1, 4 to 7 no parity bit. A mismatching parity bit sets `rx_parity_err` alongside that character. The flag is never set when no parity bit is used.
- R6: Exactly one stop bit is checked. A stop bit sampled as 0 sets `rx_frame_err`, and the character is still delivered with `rx_valid`.
- R7: The start search resumes on the sample pulse after the stop sample. Back-to-back characters with a single stop bit are all received.
- R8: `rx_valid` is a one-cycle pulse per character. `rx_data` and both flags hold their values until the next character.
- R9: The configuration is captured at start confirmation. Changing the `cfg_*` inputs during a character does not affect that character.
- R10: After reset, `rx_valid`, `rx_data`, `rx_parity_err` and `rx_frame_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | One-cycle pulse at 8x or 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length: 0..3 gives 5..8 bits |
| cfg_nine | input | 1 | 1 selects 9 data bits |
| cfg_msb_first | input | 1 | 1 means most significant bit first |
| cfg_parity | input | 3 | 0 even, 1 odd, 2 forced 0, 3 forced 1, 4..7 none |
| cfg_over8 | input | 1 | 1 = 8x oversampling, 0 = 16x |
| rx_data | output | 9 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| rx_parity_err | output | 1 | Parity mismatch on the last character |
| rx_frame_err | output | 1 | Stop bit of the last character was 0 |

## Verification
The bench drives low pulses that last exactly one sample less than half a bit, and exactly half a bit, in both oversampling modes. An off-by-one start counter would either accept the short glitch or miss the genuine start. It sends back-to-back characters with one stop bit: a receiver that waits a full stop bit before rearming would lose the second start edge. It also rewrites every configuration input in the middle of a character. A receiver that reads the live inputs would then assemble the character with the wrong length, order or parity. Random frames cover all lengths, bit orders, parity modes and both oversampling factors, with injected parity and stop-bit faults. A mis-ordered assembly, a wrong parity polarity, or a dropped flagged character each shows up as a mismatched value.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int MAX_BITS = 9;
    localparam int BIT_W    = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DATA   = 2'd1,
        PH_PARITY = 2'd2,
        PH_STOP   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [1:0] len;
        logic       nine;
        logic       msb_first;
        logic [2:0] par;
        logic       over8;
    } rx_cfg_t;

    function automatic logic [BIT_W-1:0] char_bits(input rx_cfg_t c);
        if (c.nine) return BIT_W'(9);
        return BIT_W'(5) + BIT_W'(c.len);
    endfunction

    function automatic logic parity_used(input logic [2:0] mode);
        return mode < 3'd4;
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
    import serial_rx_pkg::*;
#(
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic                rxd_s,
    input  rx_cfg_t             cfg_in,
    output logic                bit_vld,
    output phase_e              bit_phase,
    output logic                bit_val,
    output logic [BIT_W-1:0]    cur_bits,
    output logic                cur_msb,
    output logic [2:0]          cur_par
);

    localparam int CNT_W = $clog2(OVS_HI) + 1;
    localparam logic [CNT_W-1:0] FULL_HI = CNT_W'(OVS_HI);
    localparam logic [CNT_W-1:0] FULL_LO = CNT_W'(OVS_LO);
    localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(OVS_HI / 2);
    localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(OVS_LO / 2);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [BIT_W-1:0]   nbit;
        rx_cfg_t            cfg;
        logic               vld;
        phase_e             vph;
        logic               vbit;
    } ctrl_t;

    ctrl_t q, d;
    logic [CNT_W-1:0] half_live, full_cur;

    always_comb begin
        half_live = cfg_in.over8 ? HALF_LO : HALF_HI;
        full_cur  = q.cfg.over8  ? FULL_LO : FULL_HI;
        d         = q;
        d.vld     = 1'b0;
        if (sample_en) begin
            if (q.phase == PH_IDLE) begin
                if (!rxd_s) begin
                    if (q.cnt >= half_live - CNT_W'(1)) begin
                        d.phase = PH_DATA;
                        d.cnt   = '0;
                        d.nbit  = '0;
                        d.cfg   = cfg_in;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end else begin
                    d.cnt = '0;
                end
            end else if (q.cnt == full_cur - CNT_W'(1)) begin
                d.cnt  = '0;
                d.vld  = 1'b1;
                d.vph  = q.phase;
                d.vbit = rxd_s;
                case (q.phase)
                    PH_DATA: begin
                        d.nbit = q.nbit + BIT_W'(1);
                        if (q.nbit == char_bits(q.cfg) - BIT_W'(1))
                            d.phase = parity_used(q.cfg.par) ? PH_PARITY : PH_STOP;
                    end
                    PH_PARITY: d.phase = PH_STOP;
                    default: begin
                        d.phase = PH_IDLE;
                        d.nbit  = '0;
                    end
                endcase
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_vld   = q.vld;
    assign bit_phase = q.vph;
    assign bit_val   = q.vbit;
    assign cur_bits  = char_bits(q.cfg);
    assign cur_msb   = q.cfg.msb_first;
    assign cur_par   = q.cfg.par;

    // R1: while searching, the low-run counter never reaches a full half bit
    assert_start_half_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE) |-> (q.cnt < HALF_HI));

    // R2: inside a character the sample counter stays below the selected period
    assert_bit_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != PH_IDLE) |-> (q.cnt < full_cur));

    // R7: the stop sample leaves the controller already searching
    assert_rearm_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.vld && q.vph == PH_STOP) |-> (q.phase == PH_IDLE));

    // R9: captured configuration does not move inside a character
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != PH_IDLE) |=> (q.phase == PH_IDLE) || $stable(q.cfg));

endmodule

// File: rtl/serial_rx_parity.sv
module serial_rx_parity
    import serial_rx_pkg::*;
(
    input  logic [MAX_BITS-1:0] data,
    input  logic [2:0]          mode,
    output logic                used,
    output logic                expect_bit
);

    always_comb begin
        used = parity_used(mode);
        case (mode)
            3'd0:    expect_bit = ^data;
            3'd1:    expect_bit = ~(^data);
            3'd2:    expect_bit = 1'b0;
            3'd3:    expect_bit = 1'b1;
            default: expect_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/serial_rx_assemble.sv
module serial_rx_assemble
    import serial_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_vld,
    input  phase_e              bit_phase,
    input  logic                bit_val,
    input  logic [BIT_W-1:0]    nbits,
    input  logic                msb_first,
    input  logic [2:0]          par_mode,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_parity_err,
    output logic                rx_frame_err
);

    typedef struct packed {
        logic [MAX_BITS-1:0] acc;
        logic [BIT_W-1:0]    idx;
        logic                perr;
        logic [MAX_BITS-1:0] odata;
        logic                ovld;
        logic                operr;
        logic                oferr;
    } asm_t;

    asm_t q, d;
    logic [BIT_W-1:0] pos;
    logic par_used, par_expect;

    serial_rx_parity u_parity (
        .data       (q.acc),
        .mode       (par_mode),
        .used       (par_used),
        .expect_bit (par_expect)
    );

    always_comb begin
        d      = q;
        d.ovld = 1'b0;
        pos    = msb_first ? (nbits - BIT_W'(1) - q.idx) : q.idx;
        if (bit_vld) begin
            case (bit_phase)
                PH_DATA: begin
                    d.acc[pos] = bit_val;
                    d.idx      = q.idx + BIT_W'(1);
                end
                PH_PARITY: d.perr = par_used && (bit_val != par_expect);
                PH_STOP: begin
                    d.ovld  = 1'b1;
                    d.odata = q.acc;
                    d.operr = q.perr;
                    d.oferr = ~bit_val;
                    d.acc   = '0;
                    d.idx   = '0;
                    d.perr  = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data       = q.odata;
    assign rx_valid      = q.ovld;
    assign rx_parity_err = q.operr;
    assign rx_frame_err  = q.oferr;

    // R8: one strobe per character
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovld |=> !q.ovld);

    // R3: nothing above the character length is delivered
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovld |-> ((q.odata >> nbits) == '0));

    // R5: no parity error can appear when no parity bit is used
    assert_no_parity_err_when_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovld && !parity_used(par_mode)) |-> !q.operr);

    // R8: delivered values only move together with a strobe
    assert_held_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ovld |=> !q.ovld || 1'b1 ? ($stable(q.odata) || q.ovld) : 1'b1);

endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter int OVS_HI      = 16,
    parameter int OVS_LO      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic                rxd,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_nine,
    input  logic                cfg_msb_first,
    input  logic [2:0]          cfg_parity,
    input  logic                cfg_over8,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_parity_err,
    output logic                rx_frame_err
);

    logic             rxd_s;
    rx_cfg_t          cfg_in;
    logic             bit_vld, bit_val, cur_msb;
    phase_e           bit_phase;
    logic [BIT_W-1:0] cur_bits;
    logic [2:0]       cur_par;

    always_comb begin
        cfg_in.len       = cfg_len;
        cfg_in.nine      = cfg_nine;
        cfg_in.msb_first = cfg_msb_first;
        cfg_in.par       = cfg_parity;
        cfg_in.over8     = cfg_over8;
    end

    serial_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    serial_rx_ctrl #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(sample_en),
        .rxd_s    (rxd_s),
        .cfg_in   (cfg_in),
        .bit_vld  (bit_vld),
        .bit_phase(bit_phase),
        .bit_val  (bit_val),
        .cur_bits (cur_bits),
        .cur_msb  (cur_msb),
        .cur_par  (cur_par)
    );

    serial_rx_assemble u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_vld      (bit_vld),
        .bit_phase    (bit_phase),
        .bit_val      (bit_val),
        .nbits        (cur_bits),
        .msb_first    (cur_msb),
        .par_mode     (cur_par),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_parity_err(rx_parity_err),
        .rx_frame_err (rx_frame_err)
    );

endmodule

// File: tb/serial_rx_test.sv
module serial_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int SDIV       = 3;
    localparam int WD_CYCLES  = 180000;

    logic       clk, rst_n, sample_en, rxd;
    logic [1:0] cfg_len;
    logic       cfg_nine, cfg_msb_first, cfg_over8;
    logic [2:0] cfg_parity;
    logic [8:0] rx_data;
    logic       rx_valid, rx_parity_err, rx_frame_err;

    int n_chk = 0;
    int n_bad = 0;
    int pulse_errs = 0;
    bit done = 0;
    logic [10:0] rxq[$];
    logic prev_valid = 0;

    serial_rx uut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_nine(cfg_nine), .cfg_msb_first(cfg_msb_first),
        .cfg_parity(cfg_parity), .cfg_over8(cfg_over8),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
    );

    initial begin
        clk = 0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    initial begin
        sample_en = 0;
        forever begin
            repeat (SDIV - 1) @(negedge clk);
            sample_en = 1;
            @(negedge clk);
            sample_en = 0;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid) rxq.push_back({rx_frame_err, rx_parity_err, rx_data});
            if (rx_valid && prev_valid) pulse_errs++;
            prev_valid = rx_valid;
        end
    end

    function automatic int nbits_of(input logic [1:0] len, input logic nine);
        return nine ? 9 : 5 + int'(len);
    endfunction

    function automatic logic exp_par(input logic [8:0] d, input int n, input logic [2:0] mode);
        logic x = 1'b0;
        for (int i = 0; i < n; i++) x ^= d[i];
        case (mode)
            3'd0: return x;
            3'd1: return ~x;
            3'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic hold(input logic v, input int clks);
        rxd = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send_frame(input logic [1:0] len, input logic nine, input logic msb,
                              input logic [2:0] par, input logic over8, input logic [8:0] data,
                              input int nstop, input logic bad_par, input logic bad_stop,
                              input logic scramble);
        int bt = (over8 ? 8 : 16) * SDIV;
        int n  = nbits_of(len, nine);
        cfg_len = len; cfg_nine = nine; cfg_msb_first = msb;
        cfg_parity = par; cfg_over8 = over8;
        hold(1'b0, bt);
        if (scramble) begin
            cfg_len = 2'($urandom); cfg_nine = 1'($urandom);
            cfg_msb_first = ~msb; cfg_parity = 3'($urandom);
            cfg_over8 = ~over8;
        end
        for (int k = 0; k < n; k++) hold(msb ? data[n-1-k] : data[k], bt);
        if (par < 3'd4) hold(exp_par(data, n, par) ^ bad_par, bt);
        if (bad_stop) begin
            hold(1'b0, (bt * 3) / 4);
            hold(1'b1, bt - (bt * 3) / 4 + (nstop - 1) * bt);
        end else begin
            hold(1'b1, nstop * bt);
        end
    endtask

    task automatic expect_frame(input string req, input logic [8:0] ed, input logic ep, input logic ef);
        logic [10:0] e;
        check({req, " count"}, rxq.size(), 1);
        if (rxq.size() > 0) begin
            e = rxq.pop_front();
            check({req, " data"}, e[8:0], ed);
            check({req, " parity flag"}, e[9], ep);
            check({req, " frame flag"}, e[10], ef);
        end
        rxq.delete();
    endtask

    task automatic glitch_pair(input logic over8);
        int half = over8 ? 4 : 8;
        int bt   = (over8 ? 8 : 16) * SDIV;
        cfg_len = 2'd3; cfg_nine = 0; cfg_msb_first = 0; cfg_parity = 3'd4; cfg_over8 = over8;
        rxq.delete();
        // R1: one sample short of half a bit is rejected
        hold(1'b0, (half - 1) * SDIV);
        hold(1'b1, 12 * bt);
        check("R1 short low rejected", rxq.size(), 0);
        // R1 R2: exactly half a bit starts a character of all ones
        hold(1'b0, half * SDIV);
        hold(1'b1, 12 * bt);
        expect_frame("R1 R2 half-bit start", 9'h0FF, 1'b0, 1'b0);
    endtask

    initial begin
        logic [8:0] d1, d2;
        void'($urandom(32'd20240601));
        rst_n = 0; rxd = 1;
        cfg_len = 2'd3; cfg_nine = 0; cfg_msb_first = 0; cfg_parity = 3'd4; cfg_over8 = 0;
        repeat (5) @(negedge clk);
        check("R10 reset valid", rx_valid, 0);
        check("R10 reset data", rx_data, 0);
        check("R10 reset parity flag", rx_parity_err, 0);
        check("R10 reset frame flag", rx_frame_err, 0);
        rst_n = 1;
        hold(1'b1, 20);

        send_frame(2'd3, 0, 0, 3'd0, 0, 9'h0A5, 1, 0, 0, 0);
        expect_frame("R3 R5 8-bit even 16x", 9'h0A5, 0, 0);

        glitch_pair(1'b0);
        glitch_pair(1'b1);

        send_frame(2'd1, 0, 1, 3'd1, 1, 9'h02D, 1, 0, 0, 0);
        expect_frame("R4 msb-first 6-bit odd", 9'h02D, 0, 0);

        send_frame(2'd0, 1, 0, 3'd3, 0, 9'h1C3, 2, 1, 0, 0);
        expect_frame("R3 R5 nine-bit mark bad parity", 9'h1C3, 1, 0);

        send_frame(2'd2, 0, 0, 3'd2, 1, 9'h055, 1, 0, 1, 0);
        hold(1'b1, 48);
        expect_frame("R6 framing error delivered", 9'h055, 0, 1);

        send_frame(2'd3, 0, 1, 3'd0, 0, 9'h0C9, 1, 0, 0, 1);
        expect_frame("R9 mid-character config change", 9'h0C9, 0, 0);

        d1 = 9'h03C; d2 = 9'h0E1;
        send_frame(2'd3, 0, 0, 3'd4, 1, d1, 1, 0, 0, 0);
        send_frame(2'd3, 0, 0, 3'd4, 1, d2, 1, 0, 0, 0);
        check("R7 back-to-back count", rxq.size(), 2);
        if (rxq.size() == 2) begin
            check("R7 first char", rxq[0][8:0], d1);
            check("R7 second char", rxq[1][8:0], d2);
        end
        rxq.delete();

        for (int i = 0; i < 50; i++) begin
            logic [1:0] len = 2'($urandom);
            logic nine = ($urandom % 4) == 0;
            logic msb = 1'($urandom);
            logic [2:0] par = 3'($urandom);
            logic ov = 1'($urandom);
            int n = nbits_of(len, nine);
            logic [8:0] data = 9'($urandom) & 9'((1 << n) - 1);
            logic bp = (par < 3'd4) && (($urandom % 5) == 0);
            logic bs = ($urandom % 7) == 0;
            logic sc = ($urandom % 5) == 0;
            int ns = 1 + int'($urandom % 2);
            send_frame(len, nine, msb, par, ov, data, ns, bp, bs, sc);
            hold(1'b1, 2 * SDIV * 16);
            expect_frame("random R2 R3 R4 R5 R6", data, bp, bs);
        end

        check("R8 valid single-cycle pulses", pulse_errs, 0);
        finish_run();
    end

endmodule